// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block sits between a simple host port and an asynchronous, address-multiplexed DRAM. Each host read or write is turned into a sequence of active-low strobes. The row half of the address goes out with the row strobe falling. The column half follows with the column strobe falling. Read data is captured after the part's access times and returned with a single-cycle valid pulse.

After an access the row stays open. A later access to the same row only pulses the column strobe. An access to another row first closes the open row, waits out the precharge time and then opens the new row. A refresh timer raises a request at a fixed interval. The controller services it between host accesses with a column-before-row refresh cycle, closing any open row first.

Every timing is a parameter in clock cycles. The defaults assume a 10 ns clock with 60/110/15/35 ns part timings, each rounded up.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After a cycle with `rst_n` low, all four strobes are high, `dram_dq_oe` and `rsp_valid` are low, and `req_ready` is high.
- R2: The row half of `req_addr` (upper `ROW_W` bits) is on `dram_addr` when `dram_ras_n` falls. The column half (lower `COL_W` bits) is on `dram_addr` when `dram_cas_n` falls.
- R3: Two falling edges of `dram_ras_n` are at least `T_RC` cycles apart.
- R4: Two column-strobe falls within one row-open period are at least `T_PC` cycles apart.
- R5: Read data is sampled `T_CAC` cycles after `dram_cas_n` falls and `T_RAC` cycles after `dram_ras_n` falls. It is returned on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R6: An access to the row already open causes no new fall of `dram_ras_n`.
- R7: An access to a different row raises `dram_ras_n`, which then stays high at least `T_RC - T_RAC` cycles before the next fall.
- R8: While the column strobe is low for a write, `dram_we_n` is low, `dram_dq_oe` is high and `dram_oe_n` is high.
- R9: While `dram_oe_n` is low for a read, `dram_we_n` is high and `dram_dq_oe` is low.
- R10: Refresh is issued once per `REF_PERIOD` cycles, within the length of one host access. It uses a cycle where `dram_cas_n` is low before `dram_ras_n` falls, and the row strobe then stays low at least `T_RAC` cycles.
- R11: `req_ready` is low while an access or a refresh is in progress, and whenever a refresh is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | High when dram_dq_out is driven |
| dram_dq_in | input | DATA_W | Data from the DRAM |

## Verification
The bench's DRAM model returns the inverted word unless both strobes have been low for their full access times. A controller that shortened the row-to-column delay or the column pulse would therefore read back corrupt data instead of the stored pattern. Column-major sweeps force a row change on every access. These would expose a too-short precharge or row-cycle spacing, and a wrong open-row compare would return data from the stale row. Same-row bursts count row activations, so a controller that reopened the row each time shows extra activations. Refresh gaps are measured against the interval, which catches a scheduler that drops or delays a request.

// File: rtl/fpm_pkg.sv
// Shared types for the page-mode DRAM controller.
// Assumes: the state set below covers every strobe combination the controller uses.
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // no row open, waiting for a request or refresh
        ST_PRE  = 3'd1,  // row strobe high, waiting out precharge and row cycle
        ST_ACT  = 3'd2,  // row strobe low with the row address, before column
        ST_CAS  = 3'd3,  // column strobe low for one column access
        ST_OPEN = 3'd4,  // row open, column strobe high, accepting requests
        ST_COLW = 3'd5,  // page hit accepted, waiting for column spacing
        ST_RCAS = 3'd6,  // refresh: column strobe low first
        ST_RRAS = 3'd7   // refresh: both strobes low
    } fpm_state_e;

    // Index of each spacing timer in the generated timer bank.
    localparam int GAP_RC  = 0;
    localparam int GAP_PC  = 1;
    localparam int GAP_RP  = 2;
    localparam int GAP_NUM = 3;

    // True for every state that holds the row strobe low.
    function automatic logic ras_low(input fpm_state_e s);
        return (s == ST_ACT) || (s == ST_CAS) || (s == ST_OPEN) ||
               (s == ST_COLW) || (s == ST_RRAS);
    endfunction

    // True for every state that holds the column strobe low.
    function automatic logic cas_low(input fpm_state_e s);
        return (s == ST_CAS) || (s == ST_RCAS) || (s == ST_RRAS);
    endfunction

endpackage

// File: rtl/fpm_gap_timer.sv
// Minimum-spacing timer. It measures the cycles since the last start pulse
// and saturates at LIMIT. ok is high once at least LIMIT cycles have passed.
// Assumes: LIMIT >= 1. Out of reset the spacing counts as already met.
module fpm_gap_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ok
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Restart on a start pulse, otherwise count up to the limit and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= LIM_V;
        else if (start)
            cnt <= CW'(1);
        else if (cnt < LIM_V)
            cnt <= cnt + CW'(1);
    end

    assign ok = (cnt >= LIM_V);
endmodule

// File: rtl/fpm_refresh_sched.sv
// Refresh scheduler. A free-running interval counter raises pending once per
// PERIOD cycles. pending stays high until the sequencer acknowledges it.
// Assumes: PERIOD >= 2; an ack in the same cycle as a new tick keeps pending set.
module fpm_refresh_sched #(
    parameter int PERIOD = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    localparam int PW = $clog2(PERIOD);
    localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

    logic [PW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == LAST);

    // Interval counter that wraps every PERIOD cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + PW'(1);
    end

    // Pending flag: set on each tick, cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (tick)
            pending <= 1'b1;
        else if (ack)
            pending <= 1'b0;
    end
endmodule

// File: rtl/fpm_dram_ctrl.sv
// Page-mode DRAM controller top. Host requests become multiplexed row/column
// strobe sequences. The last row stays open for page hits, and refresh is
// inserted between accesses.
// Assumes: T_RAC > T_CAC, T_RC > T_RAC, T_PC > T_CAC; all timings in cycles.
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W      = 10,
    parameter int COL_W      = 10,
    parameter int DATA_W     = 16,
    parameter int T_RAC      = 6,
    parameter int T_RC       = 11,
    parameter int T_CAC      = 2,
    parameter int T_PC       = 4,
    parameter int REF_PERIOD = 780,
    localparam int AW  = ROW_W + COL_W,
    localparam int MAW = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [MAW-1:0]    dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    localparam int RCD = T_RAC - T_CAC;   // row-to-column delay
    localparam int T_RP = T_RC - T_RAC;   // precharge with row strobe high
    localparam int SW  = $clog2(T_RAC + 1);

    fpm_state_e          state, nxt;
    logic [SW-1:0]       step, step_load;
    logic [ROW_W-1:0]    cur_row;
    logic [COL_W-1:0]    cur_col;
    logic                cur_wr;
    logic [DATA_W-1:0]   cur_wdata;
    logic                have_req;
    logic                ref_pend, ref_ack;
    logic                req_fire, page_hit, cas_done;
    logic [ROW_W-1:0]    req_row;
    logic [COL_W-1:0]    req_col;
    logic [GAP_NUM-1:0]  gap_start, gap_ok;

    assign req_row  = req_addr[AW-1 -: ROW_W];
    assign req_col  = req_addr[COL_W-1:0];
    assign req_fire = req_valid && req_ready;
    assign page_hit = (state == ST_OPEN) && (req_row == cur_row);
    assign cas_done = (state == ST_CAS) && (step == '0);
    assign ref_ack  = (state == ST_IDLE) && (nxt == ST_RCAS);

    // Spacing timers: row cycle, column cycle and precharge, one per index.
    for (genvar g = 0; g < GAP_NUM; g++) begin : g_gap
        fpm_gap_timer #(
            .LIMIT((g == GAP_RC) ? T_RC : (g == GAP_PC) ? T_PC : T_RP)
        ) u_gap (
            .clk  (clk),
            .rst_n(rst_n),
            .start(gap_start[g]),
            .ok   (gap_ok[g])
        );
    end

    // Timer start events come from strobe edges implied by the state change.
    always_comb begin
        gap_start         = '0;
        gap_start[GAP_RC] = ras_low(nxt) && !ras_low(state);
        gap_start[GAP_RP] = ras_low(state) && !ras_low(nxt);
        gap_start[GAP_PC] = (nxt == ST_CAS) && (state != ST_CAS);
    end

    fpm_refresh_sched #(.PERIOD(REF_PERIOD)) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack    (ref_ack),
        .pending(ref_pend)
    );

    // Next-state decision for the strobe sequencer.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req_fire)
                    nxt = ST_PRE;
                else if (ref_pend && gap_ok[GAP_RC] && gap_ok[GAP_RP])
                    nxt = ST_RCAS;
            end
            ST_PRE: begin
                if (gap_ok[GAP_RC] && gap_ok[GAP_RP])
                    nxt = have_req ? ST_ACT : ST_IDLE;
            end
            ST_ACT:  if (step == '0) nxt = ST_CAS;
            ST_CAS:  if (step == '0) nxt = ST_OPEN;
            ST_OPEN: begin
                if (req_fire)
                    nxt = page_hit ? ST_COLW : ST_PRE;
                else if (ref_pend)
                    nxt = ST_PRE;
            end
            ST_COLW: if (gap_ok[GAP_PC]) nxt = ST_CAS;
            ST_RCAS: nxt = ST_RRAS;
            ST_RRAS: if (step == '0) nxt = ST_PRE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Dwell length, minus one, for each timed state on entry.
    always_comb begin
        unique case (nxt)
            ST_ACT:  step_load = SW'(RCD - 1);
            ST_CAS:  step_load = SW'(T_CAC - 1);
            ST_RRAS: step_load = SW'(T_RAC - 1);
            default: step_load = '0;
        endcase
    end

    // State register and dwell counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)
                step <= step_load;
            else if (step != '0)
                step <= step - SW'(1);
        end
    end

    // Latch an accepted request; the row register also tracks the open row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_row   <= '0;
            cur_col   <= '0;
            cur_wr    <= 1'b0;
            cur_wdata <= '0;
            have_req  <= 1'b0;
        end else begin
            if (req_fire) begin
                cur_row   <= req_row;
                cur_col   <= req_col;
                cur_wr    <= req_write;
                cur_wdata <= req_wdata;
                have_req  <= 1'b1;
            end else if (cas_done) begin
                have_req  <= 1'b0;
            end
        end
    end

    // Capture read data at the end of the column pulse and flag it for a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cas_done && !cur_wr;
            if (cas_done && !cur_wr)
                rsp_rdata <= dram_dq_in;
        end
    end

    // Strobes, address mux and data drive decoded from the registered state.
    always_comb begin
        dram_ras_n  = !ras_low(state);
        dram_cas_n  = !cas_low(state);
        dram_we_n   = !((state == ST_CAS) && cur_wr);
        dram_oe_n   = !((state == ST_CAS) && !cur_wr);
        dram_dq_oe  = (state == ST_CAS) && cur_wr;
        dram_dq_out = cur_wdata;
        if ((state == ST_IDLE) || (state == ST_PRE) || (state == ST_ACT))
            dram_addr = MAW'(cur_row);
        else
            dram_addr = MAW'(cur_col);
    end

    assign req_ready = ((state == ST_IDLE) || (state == ST_OPEN)) && !ref_pend;

endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
// Property checker for the page-mode DRAM controller, bound to the top.
// Assumes: it sees the top's strobes plus its internal refresh-pending flag.
module fpm_dram_ctrl_chk #(
    parameter int T_RC = 11,
    parameter int T_PC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic req_ready,
    input logic rsp_valid,
    input logic ref_pend
);
    localparam int RCW = $clog2(T_RC + 1);
    localparam int PCW = $clog2(T_PC + 1);

    logic           ras_q, cas_q;
    logic [RCW-1:0] ras_gap;
    logic [PCW-1:0] cas_gap;
    logic           ras_fall, cas_fall;

    assign ras_fall = ras_q && !ras_n;
    assign cas_fall = cas_q && !cas_n && !ras_n;

    // Previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
        end
    end

    // Cycles since the last row-strobe fall, saturating at T_RC.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ras_gap <= RCW'(T_RC);
        else if (ras_fall)
            ras_gap <= RCW'(1);
        else if (ras_gap < RCW'(T_RC))
            ras_gap <= ras_gap + RCW'(1);
    end

    // Cycles since the last column access, saturating at T_PC.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cas_gap <= PCW'(T_PC);
        else if (cas_fall)
            cas_gap <= PCW'(1);
        else if (cas_gap < PCW'(T_PC))
            cas_gap <= cas_gap + PCW'(1);
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (ras_n && cas_n && we_n && oe_n && !dq_oe && !rsp_valid)); // R1
    AST_ROW_SPACING: assert property (@(posedge clk) disable iff (!rst_n) ras_fall |-> (ras_gap >= RCW'(T_RC))); // R3
    AST_COL_SPACING: assert property (@(posedge clk) disable iff (!rst_n) cas_fall |-> (cas_gap >= PCW'(T_PC))); // R4
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R5
    AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> (!cas_n && !ras_n && oe_n && dq_oe)); // R8
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> (we_n && !dq_oe)); // R9
    AST_REFRESH_CBR: assert property (@(posedge clk) disable iff (!rst_n) (ras_fall && !cas_n) |-> !cas_q); // R10
    AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !ref_pend); // R11

endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(.T_RC(T_RC), .T_PC(T_PC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (dram_ras_n),
    .cas_n    (dram_cas_n),
    .we_n     (dram_we_n),
    .oe_n     (dram_oe_n),
    .dq_oe    (dram_dq_oe),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .ref_pend (ref_pend)
);

// File: tb/sim_fpm_dram_ctrl.sv
// Bench for the page-mode DRAM controller. A behavioural DRAM model checks the
// strobe timing. Address sweeps in row-major and column-major order check data.
module sim_fpm_dram_ctrl;
    localparam int RW = 3, CW = 3, DW = 8, AW = RW + CW, NW = 1 << AW;
    localparam int T_RAC = 6, T_RC = 11, T_CAC = 2, T_PC = 4, T_RP = T_RC - T_RAC;
    localparam int REF_P = 400, REF_SLACK = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [CW-1:0] dram_addr;
    logic          dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [DW-1:0] dram_dq_out;
    logic [DW-1:0] dram_dq_in = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    fpm_dram_ctrl #(
        .ROW_W(RW), .COL_W(CW), .DATA_W(DW), .T_RAC(T_RAC), .T_RC(T_RC),
        .T_CAC(T_CAC), .T_PC(T_PC), .REF_PERIOD(REF_P)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pattern(input int a, input int salt);
        return DW'((a * 29 + 7) ^ salt);
    endfunction

    // Behavioural DRAM model and timing monitor, evaluated between edges.
    logic [DW-1:0] mem [NW];
    int  cyc = 0, ras_age = 0, cas_age = 0, row_lat = 0, col_lat = 0;
    int  last_ras_fall = -1000, last_ras_rise = -1000, last_cas_fall = -1000;
    int  act_count = 0, ref_count = 0, last_ref = 0;
    bit  ras_prev = 1'b1, cas_prev = 1'b1, in_ref = 1'b0, cas_in_row = 1'b0;

    initial for (int i = 0; i < NW; i++) mem[i] = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!dram_ras_n && ras_prev) begin
                check(cyc - last_ras_fall >= T_RC, "R3", cyc - last_ras_fall, T_RC);
                check(cyc - last_ras_rise >= T_RP, "R7", cyc - last_ras_rise, T_RP);
                last_ras_fall = cyc;
                cas_in_row = 1'b0;
                if (!dram_cas_n) begin
                    in_ref = 1'b1;
                    ref_count++;
                    check(!req_ready, "R11", int'(req_ready), 0);
                    if (ref_count > 1)
                        check((cyc - last_ref >= REF_P - REF_SLACK) && (cyc - last_ref <= REF_P + REF_SLACK),
                              "R10", cyc - last_ref, REF_P);
                    last_ref = cyc;
                end else begin
                    in_ref = 1'b0;
                    act_count++;
                    row_lat = int'(dram_addr);   // R2 row half at row strobe fall
                end
            end
            if (dram_ras_n && !ras_prev) begin
                if (in_ref)
                    check(cyc - last_ras_fall >= T_RAC, "R10", cyc - last_ras_fall, T_RAC);
                last_ras_rise = cyc;
            end
            if (!dram_cas_n && cas_prev && !dram_ras_n) begin
                if (cas_in_row)
                    check(cyc - last_cas_fall >= T_PC, "R4", cyc - last_cas_fall, T_PC);
                cas_in_row = 1'b1;
                last_cas_fall = cyc;
                col_lat = int'(dram_addr);       // R2 column half at column strobe fall
            end
            if (!dram_cas_n && !dram_ras_n && !in_ref) begin
                if (!dram_we_n) begin
                    check(dram_oe_n && dram_dq_oe, "R8", int'({dram_oe_n, dram_dq_oe}), 3);
                    mem[(row_lat << CW) + col_lat] = dram_dq_out;
                end
                if (!dram_oe_n)
                    check(!dram_dq_oe && dram_we_n, "R9", int'({dram_dq_oe, dram_we_n}), 1);
            end
        end
        ras_age = (!dram_ras_n && !ras_prev) ? ras_age + 1 : 0;
        cas_age = (!dram_cas_n && !cas_prev) ? cas_age + 1 : 0;
        ras_prev = dram_ras_n;
        cas_prev = dram_cas_n;
        if (!dram_ras_n && !dram_cas_n && !dram_oe_n &&
            ras_age >= T_RAC - 1 && cas_age >= T_CAC - 1)
            dram_dq_in = mem[(row_lat << CW) + col_lat];
        else
            dram_dq_in = ~mem[(row_lat << CW) + col_lat];
    end

    task automatic host_req(input bit wr, input int a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(a);
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic read_chk(input int a, input logic [DW-1:0] exp);
        int w = 0;
        host_req(1'b0, a, '0);
        while (!rsp_valid && w < 100) begin
            @(negedge clk);
            w++;
        end
        check(rsp_valid && rsp_rdata == exp, "R2,R5", int'(rsp_rdata), int'(exp));
        @(negedge clk);
        check(!rsp_valid, "R5", int'(rsp_valid), 0);
    endtask

    task automatic wait_refresh();
        int r0 = ref_count;
        while (ref_count == r0) @(negedge clk);
    endtask

    initial begin
        int a0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet state after reset
        check(dram_ras_n && dram_cas_n, "R1", int'({dram_ras_n, dram_cas_n}), 3);
        check(dram_we_n && dram_oe_n, "R1", int'({dram_we_n, dram_oe_n}), 3);
        check(!dram_dq_oe && !rsp_valid, "R1", int'({dram_dq_oe, rsp_valid}), 0);
        check(req_ready, "R1", int'(req_ready), 1);

        // Row-major writes; ready must drop right after acceptance (R11)
        host_req(1'b1, 0, pattern(0, 0));
        check(!req_ready, "R11", int'(req_ready), 0);
        for (int a = 1; a < NW; a++) host_req(1'b1, a, pattern(a, 0));
        // Row-major reads: mostly page hits
        for (int a = 0; a < NW; a++) read_chk(a, pattern(a, 0));

        // Column walk: every access opens a new row (R7)
        wait_refresh();
        a0 = act_count;
        for (int r = 0; r < (1 << RW); r++) read_chk(r << CW, pattern(r << CW, 0));
        check(act_count - a0 == (1 << RW), "R7", act_count - a0, 1 << RW);

        // Full column-major read sweep
        for (int c = 0; c < (1 << CW); c++)
            for (int r = 0; r < (1 << RW); r++)
                read_chk((r << CW) + c, pattern((r << CW) + c, 0));

        // Same-row burst: a single activation (R6)
        wait_refresh();
        a0 = act_count;
        for (int c = 0; c < (1 << CW); c++) read_chk((2 << CW) + c, pattern((2 << CW) + c, 0));
        check(act_count - a0 == 1, "R6", act_count - a0, 1);

        // Page-hit rewrite of one row with a new pattern, then read back
        for (int c = 0; c < (1 << CW); c++) host_req(1'b1, (5 << CW) + c, pattern((5 << CW) + c, 8'h3C));
        for (int c = (1 << CW) - 1; c >= 0; c--) read_chk((5 << CW) + c, pattern((5 << CW) + c, 8'h3C));
        read_chk((4 << CW) + 1, pattern((4 << CW) + 1, 0));

        // Idle: refresh keeps running on its own (R10)
        a0 = ref_count;
        repeat (2 * REF_P + REF_SLACK) @(negedge clk);
        check(ref_count - a0 >= 2, "R10", ref_count - a0, 2);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule